// File: doc/BRIEF.md
# Configurable Input Glitch Filter

The block cleans up one timer input that has already been brought into the clock domain. It samples the raw level at a programmable rate and moves its filtered output to a new level only after a programmed number of consecutive samples show that level. A single 4-bit setting picks both values from a fixed table. The sample interval is 1, 2, 4, 8, 16 or 32 clocks, and the agreement count is between 2 and 8. Setting 0 turns filtering off. Besides the filtered level, the block gives a one-clock pulse whenever that level changes, so that capture or trigger logic downstream can act on clean edges.

A free-running divider sets the sample instants. It restarts whenever the setting changes, and any agreement already counted is discarded at the same time. A new setting therefore always starts from a known sample phase with a fresh count.

Top module: `sample_filter`

## Requirements
- R1: While `rstN` is low, `filtLevel` and `edgePulse` are 0, whatever `rawIn` and `filtCode` are.
- R2: With `filtCode` = 0 held steady, the input is sampled on every clock and `filtLevel` takes the value `rawIn` had before each rising edge, one clock late, for pulses as short as one clock.
- R3: Setting 1, 2 and 3 sample on every clock and need 2, 4 and 8 agreeing samples respectively.
- R4: Settings 4 and 5 sample every 2 clocks, 6 and 7 every 4 clocks, and 8 and 9 every 8 clocks. In each pair the even setting needs 6 agreeing samples and the odd setting needs 8.
- R5: Settings 10, 11 and 12 sample every 16 clocks, and settings 13, 14 and 15 sample every 32 clocks. In each group the three settings need 5, 6 and 8 agreeing samples in that order.
- R6: `filtLevel` changes only on a sample instant, and only to the sampled level, once N consecutive samples differ from the present output. A pulse on `rawIn` that covers fewer samples than that leaves `filtLevel` unchanged.
- R7: A sample that equals the present `filtLevel` restarts the agreement count. Two short opposite-level pulses separated by one matching sample do not add up.
- R8: When `filtCode` changes, the clock edge that registers the new value takes no sample. The first sample of the new setting falls on the next rising edge, and samples then repeat at the new interval.
- R9: A change of `filtCode` discards any agreement already counted. The new setting needs its full N samples, counted from its first sample.
- R10: `edgePulse` is high for exactly the one clock after each edge on which `filtLevel` changes, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the filter works on rising edges |
| rstN | input | 1 | Asynchronous reset, active low |
| filtCode | input | 4 | Setting that selects both the sample rate and the agreement count |
| rawIn | input | 1 | Input level, already synchronized to `clk` |
| filtLevel | output | 1 | Filtered level |
| edgePulse | output | 1 | One-clock marker of each change of `filtLevel` |

## Verification
The properties assume that `rawIn` and `filtCode` change only between clock edges and that they hold a defined value from the release of reset onward. The checks on setting 0 also assume that `filtCode` was 0 during reset whenever it is 0 on the first clock after reset. The stimulus drives both inputs on falling edges only and holds `filtCode` at 0 throughout reset. It changes `filtCode` only while `rawIn` is steady, except in the one deliberate test of R9, where a partial count is interrupted. Every pulse that is meant to be filtered out is shorter than the number of sample periods that would let it through.

// File: rtl/sfilt_pkg.sv
package sfilt_pkg;

  localparam int CODE_W  = 4;  // width of the filter setting
  localparam int DIV_W   = 5;  // divider counter width, covers /32
  localparam int AGREE_W = 4;  // agreement counter width, covers N up to 8

  typedef struct packed {
    logic [2:0]         rateLog;  // sample interval = 2**rateLog clocks
    logic [AGREE_W-1:0] need;     // consecutive samples needed
  } filt_cfg_t;

  typedef struct packed {
    logic               sample;   // take a sample this cycle
    logic               clear;    // setting changed: drop partial count
    logic [AGREE_W-1:0] need;     // active agreement target
  } filt_strb_t;

  function automatic filt_cfg_t decodeCfg(input logic [CODE_W-1:0] c);
    filt_cfg_t r;
    case (c)
      4'd0:    r = '{rateLog: 3'd0, need: AGREE_W'(1)};
      4'd1:    r = '{rateLog: 3'd0, need: AGREE_W'(2)};
      4'd2:    r = '{rateLog: 3'd0, need: AGREE_W'(4)};
      4'd3:    r = '{rateLog: 3'd0, need: AGREE_W'(8)};
      4'd4:    r = '{rateLog: 3'd1, need: AGREE_W'(6)};
      4'd5:    r = '{rateLog: 3'd1, need: AGREE_W'(8)};
      4'd6:    r = '{rateLog: 3'd2, need: AGREE_W'(6)};
      4'd7:    r = '{rateLog: 3'd2, need: AGREE_W'(8)};
      4'd8:    r = '{rateLog: 3'd3, need: AGREE_W'(6)};
      4'd9:    r = '{rateLog: 3'd3, need: AGREE_W'(8)};
      4'd10:   r = '{rateLog: 3'd4, need: AGREE_W'(5)};
      4'd11:   r = '{rateLog: 3'd4, need: AGREE_W'(6)};
      4'd12:   r = '{rateLog: 3'd4, need: AGREE_W'(8)};
      4'd13:   r = '{rateLog: 3'd5, need: AGREE_W'(5)};
      4'd14:   r = '{rateLog: 3'd5, need: AGREE_W'(6)};
      default: r = '{rateLog: 3'd5, need: AGREE_W'(8)};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sfilt_ctrl.sv
module sfilt_ctrl
  import sfilt_pkg::*;
#(
  parameter int DivW = DIV_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] filtCode,
  output filt_strb_t        strb
);

  logic [CODE_W-1:0] codeQ;
  logic [DivW-1:0]   divCnt;
  logic [DivW-1:0]   divLast;
  logic              codeChg;
  filt_cfg_t         cfg;

  always_comb begin
    codeChg     = (filtCode != codeQ);
    cfg         = decodeCfg(codeQ);
    divLast     = DivW'((32'd1 << cfg.rateLog) - 32'd1);
    strb.sample = !codeChg && (divCnt == '0);
    strb.clear  = codeChg;
    strb.need   = cfg.need;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ  <= '0;
      divCnt <= '0;
    end else if (codeChg) begin
      codeQ  <= filtCode;
      divCnt <= '0;
    end else if (divCnt == divLast) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

endmodule

// File: rtl/sfilt_dp.sv
module sfilt_dp
  import sfilt_pkg::*;
#(
  parameter int AgreeW = AGREE_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  filt_strb_t strb,
  input  logic       rawIn,
  output logic       filtLevel,
  output logic       edgePulse
);

  logic [AgreeW-1:0] agreeCnt;
  logic [AgreeW:0]   agreeNext;
  logic              reached;
  logic              differs;
  logic              flip;

  always_comb begin
    agreeNext = {1'b0, agreeCnt} + 1'b1;
    reached   = agreeNext >= {1'b0, AgreeW'(strb.need)};
    differs   = (rawIn != filtLevel);
    flip      = strb.sample && differs && reached;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      agreeCnt  <= '0;
      filtLevel <= 1'b0;
      edgePulse <= 1'b0;
    end else begin
      edgePulse <= flip;
      if (flip) filtLevel <= rawIn;
      if (strb.clear || (strb.sample && (!differs || reached)))
        agreeCnt <= '0;
      else if (strb.sample)
        agreeCnt <= agreeNext[AgreeW-1:0];
    end
  end

endmodule

// File: rtl/sample_filter.sv
module sample_filter
  import sfilt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] filtCode,
  input  logic              rawIn,
  output logic              filtLevel,
  output logic              edgePulse
);

  filt_strb_t strb;

  sfilt_ctrl #(.DivW(DIV_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .filtCode (filtCode),
    .strb     (strb)
  );

  sfilt_dp #(.AgreeW(AGREE_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rawIn     (rawIn),
    .filtLevel (filtLevel),
    .edgePulse (edgePulse)
  );

endmodule

// File: rtl/sfilt_chk.sv
module sfilt_chk
  import sfilt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] filtCode,
  input logic              rawIn,
  input logic              filtLevel,
  input logic              edgePulse,
  input logic              smpStrobe,
  input logic              codeClear
);

  AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (filtCode == '0 && $past(filtCode) == '0) |=> (filtLevel == $past(rawIn))); // R2

  AST_TOGGLE_TO_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    (filtLevel != $past(filtLevel)) |-> (filtLevel == $past(rawIn))); // R6

  AST_QUIET_OFF_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !smpStrobe |=> !edgePulse); // R6

  AST_NO_SAMPLE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    codeClear |-> !smpStrobe); // R8

  AST_PULSE_HAS_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |-> (filtLevel != $past(filtLevel))); // R10

  AST_TOGGLE_HAS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (filtLevel != $past(filtLevel)) |-> edgePulse); // R10

endmodule

bind sample_filter sfilt_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .filtCode  (filtCode),
  .rawIn     (rawIn),
  .filtLevel (filtLevel),
  .edgePulse (edgePulse),
  .smpStrobe (strb.sample),
  .codeClear (strb.clear)
);

// File: tb/sample_filter_tb.sv
module sample_filter_tb_top;

  typedef struct {
    int    cyc;
    logic  lvl;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] filtCode = 4'd0;
  logic       rawIn = 1'b0;
  logic       filtLevel;
  logic       edgePulse;

  int   cyc = 0;
  int   nRun = 0;
  int   nFail = 0;
  int   base = 1;
  int   curCode = 0;
  logic modelLvl = 1'b0;
  bit   done = 1'b0;
  exp_t expQ[$];

  always #5 clk = ~clk;

  sample_filter dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .filtCode  (filtCode),
    .rawIn     (rawIn),
    .filtLevel (filtLevel),
    .edgePulse (edgePulse)
  );

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  function automatic int rateOf(input int c);
    if (c <= 3)  return 1;
    if (c <= 5)  return 2;
    if (c <= 7)  return 4;
    if (c <= 9)  return 8;
    if (c <= 12) return 16;
    return 32;
  endfunction

  function automatic int needOf(input int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      3, 5, 7, 9, 12, 15: return 8;
      10, 13: return 5;
      default: return 6;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic setCode(input int c);
    if (c != curCode) begin
      filtCode = 4'(c);
      base = cyc + 2;
      curCode = c;
      @(negedge clk);
    end
  endtask

  task automatic drive(input logic val, input int hold, input string tag);
    int c, d, s, t;
    c = cyc;
    d = rateOf(curCode);
    rawIn = val;
    if (val != modelLvl) begin
      s = base;
      if (c + 1 > base) s = base + ((c + 1 - base + d - 1) / d) * d;
      t = s + (needOf(curCode) - 1) * d;
      if (t <= c + hold) begin
        expQ.push_back('{cyc: t, lvl: val, tag: tag});
        modelLvl = val;
      end
    end
    repeat (hold) @(negedge clk);
    chk(filtLevel == modelLvl, tag, "level after drive", filtLevel, modelLvl);
  endtask

  // monitor: pops expected edges as the design produces them
  always @(negedge clk) begin
    if (rstN && !done && edgePulse) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10", "unexpected edge pulse at cycle", cyc, -1);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(cyc == e.cyc, e.tag, "edge cycle", cyc, e.cyc);
        chk(filtLevel == e.lvl, e.tag, "edge level", filtLevel, e.lvl);
      end
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired: actual %0d expected %0d", 200000, 0);
    finishRun();
  end

  initial begin
    // R1: reset dominates the input
    rawIn = 1'b1;
    repeat (3) @(negedge clk);
    chk(filtLevel == 1'b0, "R1", "level in reset", filtLevel, 0);
    chk(edgePulse == 1'b0, "R1", "pulse in reset", edgePulse, 0);
    rawIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    base = 1;
    @(negedge clk);
    chk(filtLevel == 1'b0, "R1", "level after release", filtLevel, 0);

    // R2: pass-through, single-clock pulses included
    drive(1'b1, 1, "R2");
    drive(1'b0, 1, "R2");
    drive(1'b1, 3, "R2");
    drive(1'b0, 2, "R2");

    // R3: full-rate settings
    setCode(1);
    drive(1'b1, 1, "R3");
    drive(1'b0, 3, "R3");
    drive(1'b1, 2, "R3");
    setCode(2);
    drive(1'b0, 3, "R3");
    drive(1'b1, 2, "R3");
    drive(1'b0, 4, "R3");
    setCode(3);
    drive(1'b1, 7, "R3");
    drive(1'b0, 2, "R3");
    drive(1'b1, 8, "R3");

    // R7: a matching sample restarts the count
    setCode(2);
    drive(!modelLvl, 3, "R7");
    drive(modelLvl, 1, "R7");
    drive(!modelLvl, 3, "R7");
    drive(modelLvl, 4, "R7");

    // R4, R5, R6, R8: every divided setting, glitch then real edge
    for (int c = 4; c < 16; c++) begin
      string tg;
      int d, n;
      tg = (c < 10) ? "R4" : "R5";
      setCode(c);
      d = rateOf(c);
      n = needOf(c);
      drive(!modelLvl, (n - 1) * d - 1, "R6");
      drive(modelLvl, 2 * d, "R8");
      drive(!modelLvl, n * d + d, tg);
    end

    // R9: partial count does not carry over a setting change
    setCode(3);
    drive(modelLvl, 10, "R9");
    drive(!modelLvl, 5, "R9");
    setCode(1);
    drive(rawIn, 10, "R9");

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R10", "missing edge pulses", expQ.size(), 0);
    finishRun();
  end

endmodule